// File: doc/BRIEF.md
# Flash Status-Register Write-Protect Controller

This block keeps the status bits of a serial NOR flash and rules on every command that could change the array or the status bits. It stores the write-enable latch, three block-protect bits and a status-write-disable bit. It also watches an active-low write-protect pin. A command decoder upstream hands it one decoded command per cycle, with a data byte or an address. One cycle later the block answers with a single accept or reject pulse, and the status bits change at the same moment.

Two layers of protection apply. The block-protect bits fence off an upper region of sectors against program and erase. The status bits themselves can be frozen in hardware: once the status-write-disable bit is 1 and the write-protect pin is low, no status write gets through, whichever of the two conditions came last. Only raising the pin lifts this freeze. A busy input stands in for a program or erase in progress. While busy is high, only a status read is served.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After synchronous reset, `status_o` bits 7:1 are 0 and neither `acc_o` nor `rej_o` is high.
- R2: Write-enable (op 1) is accepted and sets the latch (status bit 1). Write-disable (op 2) is accepted and clears it.
- R3: A status write (op 3) with the latch clear is rejected, and the status bits do not change.
- R4: With status bit 7 at 0, a status write with the latch set is accepted at either pin level. It copies data bits 7 and 4:2 into status bits 7 and 4:2, ignores data bits 6, 5, 1 and 0, and clears the latch.
- R5: With status bit 7 at 1 and the synchronized pin high, a status write with the latch set is accepted.
- R6: With status bit 7 at 1 and the synchronized pin low, a status write is rejected. Status bits 7 and 4:2 are kept and the latch is cleared. This holds whether bit 7 was set before or after the pin went low.
- R7: Once frozen, status writes stay rejected until the pin is driven high. After that they are accepted again.
- R8: Page program (op 4) and sector erase (op 5) are rejected when the sector (address bits 19:16 of 16 sectors) lies in the fenced region, and accepted otherwise. With block-protect value k (status bits 4:2): k=0 fences nothing, k=1..4 fences the top 2^(k-1) sectors, and k>=5 fences all sectors.
- R9: Bulk erase (op 6) is rejected whenever the block-protect value is nonzero, and accepted when it is zero.
- R10: While `busy_i` is high, every command except status read (op 7) is rejected and leaves the status bits unchanged. A status read is always accepted and changes nothing. Status bit 0 mirrors `busy_i`.
- R11: Each command with `cmd_valid` high and op other than 0 yields exactly one of `acc_o`/`rej_o` one cycle later. Op 0, or no command, yields neither. Status bits 6:5 read 0.
- R12: Program and erase commands with the latch clear are rejected. Any accepted program or erase, and any program or erase rejected by the region fence, clears the latch.
- R13: The pin passes through a two-flop synchronizer. A status write issued in the same cycle as a pin fall still sees the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Asynchronous active-low write-protect pin |
| busy_i | input | 1 | Program/erase in progress |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 write-enable, 2 write-disable, 3 status write, 4 page program, 5 sector erase, 6 bulk erase, 7 status read) |
| cmd_data | input | 8 | Status byte for a status write |
| cmd_addr | input | 20 | Byte address for program/erase |
| acc_o | output | 1 | Command accepted (one-cycle pulse) |
| rej_o | output | 1 | Command rejected (one-cycle pulse) |
| status_o | output | 8 | Status byte: 7 write-disable, 4:2 block-protect, 1 latch, 0 busy |

## Verification
The assertions assume that `busy_i` holds steady across the cycle in which a command is sampled. They also judge the pin through its synchronized copy, so they take for granted that the raw pin has settled two cycles before any command whose result depends on it. The stimulus drives all inputs on the falling edge. After every pin change it waits three cycles, except in the one test where it deliberately drops the pin alongside a status write. It toggles `busy_i` only while no command is outstanding.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_PROG = 3'd4,
        OP_SECT = 3'd5,
        OP_BULK = 3'd6,
        OP_RDSR = 3'd7
    } op_e;

    localparam int SR_LOCK = 7;
    localparam int SR_BPH  = 4;
    localparam int SR_BPL  = 2;
    localparam int SR_WEL  = 1;
    localparam int SR_BUSY = 0;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
        logic       wel;
    } sreg_t;

    typedef struct packed {
        logic  acc;
        logic  rej;
        sreg_t nxt;
    } verdict_t;

    // True when the sector falls in the fenced upper region.
    function automatic logic region_locked(input logic [2:0] bp, input int sector,
                                           input int sec_bits);
        int k;
        k = int'(bp);
        if (k == 0) return 1'b0;
        if (k - 1 >= sec_bits) return 1'b1;
        return sector >= ((1 << sec_bits) - (1 << (k - 1)));
    endfunction

    function automatic logic [7:0] pack_status(input sreg_t s, input logic busy);
        logic [7:0] b;
        b               = '0;
        b[SR_LOCK]      = s.lock;
        b[SR_BPH:SR_BPL] = s.bp;
        b[SR_WEL]       = s.wel;
        b[SR_BUSY]      = busy;
        return b;
    endfunction

endpackage

// File: rtl/fwp_sync.sv
module fwp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/fwp_decide.sv
module fwp_decide
    import fwp_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SEC_BITS = 4
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              busy,
    input  logic              pin_hi,
    input  sreg_t             cur,
    output verdict_t          v
);
    logic [SEC_BITS-1:0] sector;
    logic                fenced;
    op_e                 op;

    assign op     = op_e'(cmd_op);
    assign sector = cmd_addr[ADDR_W-1 -: SEC_BITS];
    assign fenced = region_locked(cur.bp, int'(32'(sector)), SEC_BITS);

    always_comb begin
        v.acc = 1'b0;
        v.rej = 1'b0;
        v.nxt = cur;
        if (cmd_valid && op != OP_NOP) begin
            if (busy && op != OP_RDSR) begin
                v.rej = 1'b1;
            end else begin
                case (op)
                    OP_WREN: begin v.acc = 1'b1; v.nxt.wel = 1'b1; end
                    OP_WRDI: begin v.acc = 1'b1; v.nxt.wel = 1'b0; end
                    OP_RDSR: v.acc = 1'b1;
                    OP_WRSR: begin
                        if (!cur.wel) begin
                            v.rej = 1'b1;
                        end else if (cur.lock && !pin_hi) begin
                            v.rej     = 1'b1;
                            v.nxt.wel = 1'b0;
                        end else begin
                            v.acc      = 1'b1;
                            v.nxt.lock = cmd_data[SR_LOCK];
                            v.nxt.bp   = cmd_data[SR_BPH:SR_BPL];
                            v.nxt.wel  = 1'b0;
                        end
                    end
                    OP_PROG, OP_SECT: begin
                        if (!cur.wel) begin
                            v.rej = 1'b1;
                        end else begin
                            v.nxt.wel = 1'b0;
                            v.acc     = !fenced;
                            v.rej     = fenced;
                        end
                    end
                    OP_BULK: begin
                        if (!cur.wel) begin
                            v.rej = 1'b1;
                        end else begin
                            v.nxt.wel = 1'b0;
                            v.acc     = (cur.bp == 3'd0);
                            v.rej     = (cur.bp != 3'd0);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fwp_status.sv
module fwp_status
    import fwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t v,
    output sreg_t    cur,
    output logic     acc,
    output logic     rej
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            acc <= 1'b0;
            rej <= 1'b0;
        end else begin
            cur <= v.nxt;
            acc <= v.acc;
            rej <= v.rej;
        end
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import fwp_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SEC_BITS   = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              busy_i,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              acc_o,
    output logic              rej_o,
    output logic [7:0]        status_o
);
    logic     wp_hi;
    sreg_t    cur;
    verdict_t v;

    fwp_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_i(wp_n), .sync_o(wp_hi)
    );

    fwp_decide #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS)) u_decide (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_addr(cmd_addr), .busy(busy_i), .pin_hi(wp_hi), .cur(cur), .v(v)
    );

    fwp_status u_state (
        .clk(clk), .rst(rst), .v(v), .cur(cur), .acc(acc_o), .rej(rej_o)
    );

    assign status_o = pack_status(cur, busy_i);
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy_i,
    input logic       wp_hi,
    input logic       acc_o,
    input logic       rej_o,
    input logic [7:0] status_o
);
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(acc_o && rej_o)); // R11

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == 3'd0) |=> (!acc_o && !rej_o)); // R11

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy_i && cmd_op != 3'd0 && cmd_op != 3'd7)
        |=> (rej_o && $stable(status_o[7:2]))); // R10

    AST_READ_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd7) |=> (acc_o && $stable(status_o[7:1]))); // R10

    AST_WRSR_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3 && !status_o[1])
        |=> (rej_o && $stable(status_o[7:1]))); // R3

    AST_HW_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3 && status_o[7] && !wp_hi)
        |=> (rej_o && $stable(status_o[7:2]))); // R6

    AST_BULK_FENCED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd6 && status_o[4:2] != 3'd0) |=> rej_o); // R9
endmodule

bind flash_wp_ctrl fwp_checker u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy_i(busy_i), .wp_hi(wp_hi), .acc_o(acc_o), .rej_o(rej_o),
    .status_o(status_o)
);

// File: tb/flash_wp_ctrl_test.sv
module flash_wp_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_n = 1'b1;
    logic        busy_i = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic [19:0] cmd_addr = 20'd0;
    logic        acc_o, rej_o;
    logic [7:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic got_acc, got_rej;

    flash_wp_ctrl uut (
        .clk(clk), .rst(rst), .wp_n(wp_n), .busy_i(busy_i),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_addr(cmd_addr), .acc_o(acc_o), .rej_o(rej_o), .status_o(status_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives at a falling edge; returns at the next falling edge with the verdict.
    task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [19:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_addr = a;
        @(negedge clk);
        got_acc = acc_o; got_rej = rej_o;
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_status(input logic [7:0] d);
        issue(3'd1, 8'h00, 20'h0);
        issue(3'd3, d, 20'h0);
    endtask

    function automatic logic fenced(input int bp, input int sec);
        if (bp == 0) return 1'b0;
        if (bp >= 5) return 1'b1;
        return sec >= 16 - (2 ** (bp - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 status", {24'd0, status_o}, 32'h00);
        check("R1 pulses", {30'd0, acc_o, rej_o}, 32'd0);

        // R11 idle and op 0 give no pulse
        issue(3'd0, 8'h00, 20'h0);
        check("R11 nop", {30'd0, got_acc, got_rej}, 32'd0);

        // R2
        issue(3'd1, 8'h00, 20'h0);
        check("R2 wren", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h02});
        issue(3'd2, 8'h00, 20'h0);
        check("R2 wrdi", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h00});

        // R3
        issue(3'd3, 8'hFC, 20'h0);
        check("R3 no latch", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h00});

        // R4 with pin low and lock bit clear
        wp_n = 1'b0; settle();
        set_status(8'h0C);
        check("R4 write", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h0C});
        set_status(8'h63);
        check("R4 ignored bits", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h00});

        // R5 lock set with pin high
        wp_n = 1'b1; settle();
        set_status(8'h80);
        check("R5 set lock", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h80});
        set_status(8'h84);
        check("R5 write", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h84});

        // R6 pin falls after lock set
        wp_n = 1'b0; settle();
        set_status(8'h00);
        check("R6 frozen", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h84});
        // R7 stays frozen while low, released by pin high
        set_status(8'h00);
        check("R7 still frozen", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h84});
        wp_n = 1'b1; settle();
        set_status(8'h00);
        check("R7 released", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h00});

        // R6 lock set after pin low
        wp_n = 1'b0; settle();
        set_status(8'h80);
        check("R6 lock while low", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h80});
        set_status(8'h00);
        check("R6 frozen order b", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h80});

        // R13 synchronizer delay
        wp_n = 1'b1; settle();
        issue(3'd1, 8'h00, 20'h0);
        wp_n = 1'b0;
        issue(3'd3, 8'h88, 20'h0);
        check("R13 old level", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h88});
        settle();
        set_status(8'h00);
        check("R13 new level", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h88});
        wp_n = 1'b1; settle();
        set_status(8'h00);
        check("R7 clear", {24'd0, status_o}, 32'h00);

        // R8 / R12 sweep of region fence
        for (int bp = 0; bp < 8; bp++) begin
            for (int sec = 0; sec < 16; sec++) begin
                for (int k = 0; k < 2; k++) begin
                    logic exp_f;
                    exp_f = fenced(bp, sec);
                    set_status(8'(bp << 2));
                    issue(3'd1, 8'h00, 20'h0);
                    issue(k == 0 ? 3'd4 : 3'd5, 8'h00,
                          {4'(sec), 16'(sec * 1234 + 7)});
                    check("R8 fence", {30'd0, got_acc, got_rej}, {30'd0, !exp_f, exp_f});
                    check("R12 latch cleared", {24'd0, status_o}, 32'(bp << 2));
                end
            end
            // R9
            issue(3'd1, 8'h00, 20'h0);
            issue(3'd6, 8'h00, 20'h0);
            check("R9 bulk", {30'd0, got_acc, got_rej}, {30'd0, bp == 0, bp != 0});
        end

        // R12 no latch
        set_status(8'h00);
        issue(3'd4, 8'h00, 20'h12345);
        check("R12 prog no latch", {30'd0, got_acc, got_rej}, 32'd1);
        issue(3'd6, 8'h00, 20'h0);
        check("R12 bulk no latch", {30'd0, got_acc, got_rej}, 32'd1);

        // R10 busy
        issue(3'd1, 8'h00, 20'h0);
        busy_i = 1'b1;
        @(negedge clk);
        check("R10 busy bit", {24'd0, status_o}, 32'h03);
        issue(3'd3, 8'h0C, 20'h0);
        check("R10 wrsr busy", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h03});
        issue(3'd2, 8'h00, 20'h0);
        check("R10 wrdi busy", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b01, 8'h03});
        issue(3'd7, 8'h00, 20'h0);
        check("R10 read busy", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h03});
        busy_i = 1'b0;
        issue(3'd7, 8'h00, 20'h0);
        check("R10 read idle", {22'd0, got_acc, got_rej, status_o}, {22'd0, 2'b10, 8'h02});
        @(negedge clk);
        check("R11 single pulse", {30'd0, acc_o, rej_o}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule